// File: doc/BRIEF.md
# Sixteen-bit Grouped-Opcode ALU

This block is a purely combinational arithmetic and logic unit for a 16-bit datapath. An operation is chosen by two fields: a 2-bit group selector and a 3-bit function code within that group. Three groups are handled here:
- bitwise logic, add/subtract and shifts;
- signed and unsigned comparisons that return a boolean;
- register moves, including a byte-merge that builds the upper half of the result.

The fourth group is reserved for a multiply/divide unit that lives outside this block. For that group the ALU drives a zero result and raises a decode output, so the surrounding datapath can substitute the external unit's result.

Both operands, the result and every internal path are sized from a width parameter whose default is 16. A zero flag accompanies every result. There is no clock, no state, and no carry or overflow output.

Top module: `alu16_grouped`

## Requirements
- R1: With group 00, function 000 gives A AND B, 001 gives A OR B, 010 gives A XOR B, and 011 gives NOT A.
- R2: With group 00, function 100 gives A+B and 101 gives A−B, both wrapping modulo 2^16.
- R3: With group 00, function 110 is an arithmetic shift of A and 111 is a logical shift of A.
  - The amount is B[4:0], read as two's complement in −16..15.
  - Zero or positive amounts shift left with zero fill.
  - Negative amounts shift right by the magnitude. The arithmetic form fills with A[15] and the logical form fills with zero.
- R4: A shift amount of −16 (B[4:0]=10000) gives all zeros for the logical shift and sixteen copies of A[15] for the arithmetic shift. B[15:5] has no effect on any shift.
- R5: With group 01, the functions return a boolean in bit 0 with bits 15..1 cleared:
  - 000 is signed A<B;
  - 001 is signed A≤B;
  - 011 is A==B;
  - 100 is unsigned A<B;
  - 101 is unsigned A≤B.
- R6: With group 10, function 000 passes B unchanged to the result.
- R7: With group 10, function 001 gives {B[7:0], A[7:0]}.
- R8: Unused codes give a result of 0x0000. These are group 01 with function 010, 110 or 111, and group 10 with function 010 through 111.
- R9: With group 11 (any function), the result is 0x0000 and the external-unit select output is 1. The select output is 0 for every other group.
- R10: The zero flag is 1 exactly when the result equals 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand (A) |
| b_i | input | 16 | Second operand (B); also carries the shift amount |
| grp_i | input | 2 | Operation group selector |
| fn_i | input | 3 | Function code within the group |
| res_o | output | 16 | Result |
| zero_o | output | 1 | High when the result is all zeros |
| ext_sel_o | output | 1 | High when the group belongs to the external multiply/divide unit |

## Verification
The bench drives shifts at every amount from −16 to 15 in both directions and both fill modes. A wrong sign interpretation of B[4:0] would send negative amounts left, and a missed −16 case would leave the operand unshifted or fill with the wrong bit. Compare operands are picked where the signed and unsigned orders disagree (0x8000 against 0x0001) and at equality, so a swapped signedness or a strict/non-strict mix-up gives a wrong bit 0. Every unused code and all of group 11 are swept with non-zero operands, so a design that leaks an operand or an adder result into a reserved slot shows a non-zero result. The zero flag and the external select are compared on every vector.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_CMP   = 2'b01,
    GRP_MOVE  = 2'b10,
    GRP_EXT   = 2'b11
  } alu_grp_e;

  // arithmetic/logic group function codes
  localparam logic [2:0] FN_AND  = 3'b000;
  localparam logic [2:0] FN_OR   = 3'b001;
  localparam logic [2:0] FN_XOR  = 3'b010;
  localparam logic [2:0] FN_NOTA = 3'b011;
  localparam logic [2:0] FN_ADD  = 3'b100;
  localparam logic [2:0] FN_SUB  = 3'b101;
  localparam logic [2:0] FN_SHA  = 3'b110;
  localparam logic [2:0] FN_SHL  = 3'b111;

  // compare group function codes
  localparam logic [2:0] FN_SLT  = 3'b000;
  localparam logic [2:0] FN_SLE  = 3'b001;
  localparam logic [2:0] FN_EQ   = 3'b011;
  localparam logic [2:0] FN_ULT  = 3'b100;
  localparam logic [2:0] FN_ULE  = 3'b101;

  // move group function codes
  localparam logic [2:0] FN_PASSB = 3'b000;
  localparam logic [2:0] FN_MERGE = 3'b001;

endpackage

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
  parameter int W = 16
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] amt_i,
  input  logic         arith_i,
  output logic [W-1:0] res_o
);
  localparam int SHW = $clog2(W) + 1;

  logic [SHW-1:0]     amt_raw;
  logic               go_right;
  logic [SHW-1:0]     mag;
  logic               fill;
  logic [W-1:0]       stage_in;
  logic [SHW:0][W-1:0] stg;
  logic [W-1:0]       stage_out;

  assign amt_raw  = amt_i[SHW-1:0];
  assign go_right = amt_raw[SHW-1];
  assign mag      = go_right ? (~amt_raw + 1'b1) : amt_raw;
  assign fill     = go_right & arith_i & src_i[W-1];

  // left shifts reuse the right-shift network on a bit-reversed operand
  always_comb begin
    for (int i = 0; i < W; i++) begin
      stage_in[i] = go_right ? src_i[i] : src_i[W-1-i];
    end
  end

  assign stg[0] = stage_in;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (STEP >= W) begin : g_full
      assign stg[k+1] = mag[k] ? {W{fill}} : stg[k];
    end else begin : g_part
      assign stg[k+1] = mag[k] ? {{STEP{fill}}, stg[k][W-1:STEP]} : stg[k];
    end
  end

  assign stage_out = stg[SHW];

  always_comb begin
    for (int i = 0; i < W; i++) begin
      res_o[i] = go_right ? stage_out[i] : stage_out[W-1-i];
    end
  end

  always_comb begin
    // R3
    left_lsb_zero_chk: assert (go_right || (mag == '0) || (res_o[0] == 1'b0))
      else $error("left shift brought a non-zero bit into the LSB");
    // R4
    full_right_fill_chk: assert (!(go_right && (mag == SHW'(W))) ||
                                 (res_o == {W{arith_i & src_i[W-1]}}))
      else $error("full-width right shift did not produce pure fill");
  end

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   fn_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic [W-1:0] shifted;
  logic         use_arith;

  assign sum       = a_i + b_i;
  assign diff      = a_i - b_i;
  assign use_arith = (fn_i == FN_SHA);

  alu16_shifter #(.W(W)) i_shift (
    .src_i   (a_i),
    .amt_i   (b_i),
    .arith_i (use_arith),
    .res_o   (shifted)
  );

  always_comb begin
    unique case (fn_i)
      FN_AND:         res_o = a_i & b_i;
      FN_OR:          res_o = a_i | b_i;
      FN_XOR:         res_o = a_i ^ b_i;
      FN_NOTA:        res_o = ~a_i;
      FN_ADD:         res_o = sum;
      FN_SUB:         res_o = diff;
      FN_SHA, FN_SHL: res_o = shifted;
      default:        res_o = '0;
    endcase
  end

  always_comb begin
    // R2
    add_sub_inverse_chk: assert (!(fn_i == FN_SUB) || ((res_o + b_i) == a_i))
      else $error("subtraction result does not undo addition");
  end

endmodule

// File: rtl/alu16_compare.sv
module alu16_compare
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   fn_i,
  output logic [W-1:0] res_o
);
  logic lt_s, lt_u, eq;
  logic flag;

  assign lt_s = $signed(a_i) < $signed(b_i);
  assign lt_u = a_i < b_i;
  assign eq   = (a_i == b_i);

  always_comb begin
    case (fn_i)
      FN_SLT:  flag = lt_s;
      FN_SLE:  flag = lt_s | eq;
      FN_EQ:   flag = eq;
      FN_ULT:  flag = lt_u;
      FN_ULE:  flag = lt_u | eq;
      default: flag = 1'b0;
    endcase
  end

  assign res_o = {{(W-1){1'b0}}, flag};

  always_comb begin
    // R5
    cmp_upper_clear_chk: assert (res_o[W-1:1] == '0)
      else $error("compare result has upper bits set");
    // R5
    cmp_eq_le_chk: assert (!(fn_i == FN_SLE && eq) || res_o[0])
      else $error("signed less-or-equal false on equal operands");
  end

endmodule

// File: rtl/alu16_move.sv
module alu16_move
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   fn_i,
  output logic [W-1:0] res_o
);
  localparam int H = W / 2;

  always_comb begin
    case (fn_i)
      FN_PASSB: res_o = b_i;
      FN_MERGE: res_o = {b_i[H-1:0], a_i[H-1:0]};
      default:  res_o = '0;
    endcase
  end

  always_comb begin
    // R7
    merge_low_keep_chk: assert (!(fn_i == FN_MERGE) || (res_o[H-1:0] == a_i[H-1:0]))
      else $error("byte merge lost the low half of A");
  end

endmodule

// File: rtl/alu16_grouped.sv
module alu16_grouped
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   grp_i,
  input  logic [2:0]   fn_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         ext_sel_o
);
  alu_grp_e     grp;
  logic [W-1:0] arith_res;
  logic [W-1:0] cmp_res;
  logic [W-1:0] move_res;

  assign grp = alu_grp_e'(grp_i);

  alu16_arith #(.W(W)) i_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .fn_i  (fn_i),
    .res_o (arith_res)
  );

  alu16_compare #(.W(W)) i_cmp (
    .a_i   (a_i),
    .b_i   (b_i),
    .fn_i  (fn_i),
    .res_o (cmp_res)
  );

  alu16_move #(.W(W)) i_move (
    .a_i   (a_i),
    .b_i   (b_i),
    .fn_i  (fn_i),
    .res_o (move_res)
  );

  always_comb begin
    unique case (grp)
      GRP_ARITH: res_o = arith_res;
      GRP_CMP:   res_o = cmp_res;
      GRP_MOVE:  res_o = move_res;
      default:   res_o = '0;
    endcase
  end

  assign zero_o    = ~|res_o;
  assign ext_sel_o = (grp == GRP_EXT);

  always_comb begin
    // R9
    ext_group_zero_chk: assert (!ext_sel_o || (res_o == '0 && zero_o))
      else $error("reserved group produced a non-zero result");
    // R10
    cmp_true_nonzero_chk: assert (!(grp == GRP_CMP && cmp_res[0]) || !zero_o)
      else $error("zero flag set on a true comparison");
  end

endmodule

// File: tb/test_alu16_grouped.sv
module test_alu16_grouped;
  logic        clk;
  logic        rst_n;
  logic [15:0] a, b;
  logic [1:0]  grp;
  logic [2:0]  fn;
  logic [15:0] res;
  logic        zero, ext;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  alu16_grouped i_alu16_grouped (
    .a_i(a), .b_i(b), .grp_i(grp), .fn_i(fn),
    .res_o(res), .zero_o(zero), .ext_sel_o(ext)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int shift_amt(logic [15:0] bv);
    int v = int'(bv[4:0]);
    if (v >= 16) v -= 32;
    return v;
  endfunction

  function automatic logic [15:0] model(logic [15:0] av, logic [15:0] bv,
                                        logic [1:0] g, logic [2:0] f);
    int sa, amt;
    case (g)
      2'd0: case (f)
        3'd0: return av & bv;
        3'd1: return av | bv;
        3'd2: return av ^ bv;
        3'd3: return ~av;
        3'd4: return 16'((int'(av) + int'(bv)) % 65536);
        3'd5: return 16'((int'(av) - int'(bv) + 65536) % 65536);
        default: begin
          amt = shift_amt(bv);
          if (amt >= 0) return 16'(av << amt);
          sa = (f == 3'd6) ? int'($signed(av)) : int'(av);
          return 16'(sa >>> (-amt));
        end
      endcase
      2'd1: case (f)
        3'd0: return {15'd0, $signed(av) <  $signed(bv)};
        3'd1: return {15'd0, $signed(av) <= $signed(bv)};
        3'd3: return {15'd0, av == bv};
        3'd4: return {15'd0, av <  bv};
        3'd5: return {15'd0, av <= bv};
        default: return 16'd0;
      endcase
      2'd2: case (f)
        3'd0: return bv;
        3'd1: return {bv[7:0], av[7:0]};
        default: return 16'd0;
      endcase
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag(logic [15:0] bv, logic [1:0] g, logic [2:0] f);
    if (g == 2'd0) begin
      if (f < 3'd4) return "R1";
      if (f < 3'd6) return "R2";
      return (shift_amt(bv) == -16) ? "R4" : "R3";
    end
    if (g == 2'd1) return (f == 3'd2 || f >= 3'd6) ? "R8" : "R5";
    if (g == 2'd2) return (f == 3'd0) ? "R6" : ((f == 3'd1) ? "R7" : "R8");
    return "R9";
  endfunction

  task automatic apply(logic [15:0] av, logic [15:0] bv, logic [1:0] g, logic [2:0] f);
    logic [15:0] exp_r;
    @(posedge clk);
    a = av; b = bv; grp = g; fn = f;
    @(negedge clk);
    exp_r = model(av, bv, g, f);
    checks++;
    if (res !== exp_r) begin
      errors++;
      $display("FAIL %s g=%0d f=%0d a=%h b=%h: res=%h expected %h",
               tag(bv, g, f), g, f, av, bv, res, exp_r);
    end
    checks++;
    if (zero !== (exp_r == 16'd0)) begin
      errors++;
      $display("FAIL R10 zero flag: got %b expected %b", zero, exp_r == 16'd0);
    end
    checks++;
    if (ext !== (g == 2'd3)) begin
      errors++;
      $display("FAIL R9 ext select: got %b expected %b", ext, g == 2'd3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; grp = '0; fn = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // idle state: AND of zeros -> zero result, flag high (R1, R10)
    apply(16'h0000, 16'h0000, 2'd0, 3'd0);
    // R1 logic ops
    for (int f = 0; f < 4; f++) apply(16'hF0F3, 16'h3C5A, 2'd0, 3'(f));
    // R2 wrap
    apply(16'hFFFF, 16'h0001, 2'd0, 3'd4);
    apply(16'h0000, 16'h0001, 2'd0, 3'd5);
    apply(16'h7FFF, 16'h0001, 2'd0, 3'd4);
    // R3, R4: every amount, both fills, junk in B[15:5]
    for (int s = 0; s < 32; s++) begin
      apply(16'h8E71, 16'(s) | 16'hA5E0, 2'd0, 3'd6);
      apply(16'h8E71, 16'(s), 2'd0, 3'd7);
      apply(16'h4E71, 16'(s), 2'd0, 3'd6);
    end
    // R5 signed vs unsigned and equality
    for (int f = 0; f < 8; f++) begin
      apply(16'h8000, 16'h0001, 2'd1, 3'(f));
      apply(16'h0001, 16'h8000, 2'd1, 3'(f));
      apply(16'h1234, 16'h1234, 2'd1, 3'(f));
    end
    // R6, R7, R8 move group
    for (int f = 0; f < 8; f++) apply(16'hABCD, 16'h5E12, 2'd2, 3'(f));
    // R9 reserved group
    for (int f = 0; f < 8; f++) apply(16'hFFFF, 16'h7FFF, 2'd3, 3'(f));
    // random sweep
    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), 2'($urandom), 3'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule